// File: doc/BRIEF.md
# Multichannel PWM Waveform Generator

A bank of independent pulse-width channels. Each channel drives its pin high for a programmed number of ticks, then low for a second programmed number of ticks, and repeats this while it is enabled. A per-channel power-of-two prescaler sets the tick rate. Software reaches every control through a flat word-addressed register port: prescale fields, channel enable (separate write-one-to-set and write-one-to-clear words plus a read-only status word), the level a channel drives before it first runs and after it is stopped, and a per-pin output-enable.

Tick counts are written into a shadow copy. A channel uses new counts only after an explicit per-channel update request. A running channel takes them at the end of its low phase, so a phase is never cut short. A stopped channel takes them on the next clock. A busy bit stays set while the request is pending.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every channel is disabled, every register reads zero, every `pwm_out` and `pwm_oe` bit is 0, and no busy bit is set.
- R2: A write to word 2 sets the enable of each channel whose data bit is 1. A write to word 3 clears the enable of each channel whose data bit is 1. Word 4 reads the enable bits, with channel c in bit c.
- R3: Channel c takes its 4-bit prescale n from word 0 (channels 0–7) or word 1 (channels 8–15), at bits 4*(c mod 8)+3 down to 4*(c mod 8). The channel's tick rate is the clock divided by 2^n.
- R4: Word 32+c holds the high tick count of channel c in bits 31:16 and its low tick count in bits 15:0. From enable, the output is high for high*2^n clocks, then low for low*2^n clocks, then repeats.
- R5: While a channel is enabled, a high count of 0 holds its output low and a low count of 0 holds its output high.
- R6: Writing 1 to bit c of word 5 requests an update of channel c. Bit c of word 6 reads 1 until the update is applied. A running channel applies it only at the end of its low phase. Until then the old counts keep shaping the output.
- R7: A disabled channel applies a requested update on the next clock edge, so its busy bit is set for exactly one cycle.
- R8: Word 7 holds an initial level for channel c in bit c and a finishing level in bit 16+c. A disabled channel that has not run since reset drives its initial level. A channel stopped after running drives its finishing level.
- R9: Bit c of word 8 drives `pwm_oe[c]`.
- R10: Zero bits written to words 2, 3 or 5 change no enable bit and no busy bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Word address for the write or the read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 16 | Waveform level, one bit per channel |
| pwm_oe | output | 16 | Pin drive enable, one bit per channel |

## Verification
The hardest situation to reach is an update request that arrives while a channel is in the middle of a period. The check must show both that the shadow counts do not leak into the current phase and that they take over at exactly the low-to-high boundary. The bench starts a channel at a known clock edge with equal high and low counts. It rewrites the shadow word and raises the update request a fixed number of cycles later. It then samples the output and the busy word at every clock up to the boundary and just past it. The degenerate zero-count waveforms and the finishing level after a stop are reached with short directed sequences.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // Word addresses of the register port
  localparam int unsigned A_PSC0   = 0;
  localparam int unsigned A_PSC1   = 1;
  localparam int unsigned A_ENSET  = 2;
  localparam int unsigned A_ENCLR  = 3;
  localparam int unsigned A_ENSTAT = 4;
  localparam int unsigned A_UPD    = 5;
  localparam int unsigned A_BUSY   = 6;
  localparam int unsigned A_LVL    = 7;
  localparam int unsigned A_OE     = 8;
  localparam int unsigned A_WAVE   = 32;

  localparam int unsigned FIN_LSB  = 16;

  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} phase_e;

  // A tick fires when the low `shift` bits of the prescale counter are all ones
  function automatic logic tick_due(input logic [31:0] pre, input logic [4:0] shift);
    logic [31:0] mask;
    mask = (32'd1 << shift) - 32'd1;
    return (pre & mask) == mask;
  endfunction

  // True on the last tick of a phase that lasts `lim` ticks
  function automatic logic phase_done(input logic [31:0] cnt, input logic [31:0] lim);
    return (cnt + 32'd1) >= lim;
  endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 16,
  parameter int PW  = 4,
  parameter int AW  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic [AW-1:0]            bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NCH-1:0]           apply,
  output logic [NCH-1:0]           en,
  output logic [NCH-1:0]           busy,
  output logic [NCH-1:0]           oe,
  output logic [NCH-1:0]           init_lvl,
  output logic [NCH-1:0]           fin_lvl,
  output logic [NCH-1:0][PW-1:0]   psc,
  output logic [NCH-1:0][CW-1:0]   shd_hi,
  output logic [NCH-1:0][CW-1:0]   shd_lo
);
  localparam int PER_WORD = 32 / PW;
  localparam int NWORD    = (NCH + PER_WORD - 1) / PER_WORD;

  logic [NWORD-1:0][31:0] psc_q;
  logic [31:0]            lvl_q;
  logic [NCH-1:0]         set_w, clr_w, upd_w;

  function automatic logic hit(input logic [AW-1:0] a, input int unsigned w);
    return bus_wr && (a == AW'(w));
  endfunction

  assign set_w = hit(bus_addr, A_ENSET) ? bus_wdata[NCH-1:0] : '0;
  assign clr_w = hit(bus_addr, A_ENCLR) ? bus_wdata[NCH-1:0] : '0;
  assign upd_w = hit(bus_addr, A_UPD)   ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= '0;
      busy  <= '0;
      oe    <= '0;
      lvl_q <= '0;
    end else begin
      en   <= (en | set_w) & ~clr_w;
      busy <= (busy & ~apply) | upd_w;
      if (hit(bus_addr, A_OE))  oe    <= bus_wdata[NCH-1:0];
      if (hit(bus_addr, A_LVL)) lvl_q <= bus_wdata;
    end
  end

  assign init_lvl = lvl_q[NCH-1:0];
  assign fin_lvl  = lvl_q[FIN_LSB +: NCH];

  for (genvar w = 0; w < NWORD; w++) begin : g_pword
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            psc_q[w] <= '0;
      else if (hit(bus_addr, A_PSC0 + w))    psc_q[w] <= bus_wdata;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign psc[c] = psc_q[c / PER_WORD][PW*(c % PER_WORD) +: PW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shd_hi[c] <= '0;
        shd_lo[c] <= '0;
      end else if (hit(bus_addr, A_WAVE + c)) begin
        shd_hi[c] <= bus_wdata[16 +: CW];
        shd_lo[c] <= bus_wdata[0 +: CW];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(A_ENSTAT))   bus_rdata[NCH-1:0] = en;
    else if (bus_addr == AW'(A_BUSY)) bus_rdata[NCH-1:0] = busy;
    else if (bus_addr == AW'(A_OE))   bus_rdata[NCH-1:0] = oe;
    else if (bus_addr == AW'(A_LVL))  bus_rdata = lvl_q;
    for (int w = 0; w < NWORD; w++)
      if (bus_addr == AW'(A_PSC0 + w)) bus_rdata = psc_q[w];
    for (int c = 0; c < NCH; c++)
      if (bus_addr == AW'(A_WAVE + c)) begin
        bus_rdata[16 +: CW] = shd_hi[c];
        bus_rdata[0 +: CW]  = shd_lo[c];
      end
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          busy,
  input  logic [PW-1:0] psc,
  input  logic [CW-1:0] shd_hi,
  input  logic [CW-1:0] shd_lo,
  input  logic          init_lvl,
  input  logic          fin_lvl,
  output logic          out,
  output logic          apply,
  output logic          boundary,
  output logic          hi_zero,
  output logic          lo_zero
);
  localparam int PRE_W = (1 << PW) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [CW-1:0]    act_hi, act_lo, cnt_q, nxt_hi, nxt_lo;
  phase_e           phase_q;
  logic             ran_q, tick, end_hi, end_lo;

  assign tick    = en && tick_due(32'(pre_q), 5'(psc));
  assign end_hi  = tick && phase_q == PH_HIGH && phase_done(32'(cnt_q), 32'(act_hi));
  assign end_lo  = tick && phase_q == PH_LOW  && phase_done(32'(cnt_q), 32'(act_lo));
  assign hi_zero = act_hi == '0;
  assign lo_zero = act_lo == '0;

  // A period ends after the low phase, or after the high phase when no low phase exists
  assign boundary = end_lo || (end_hi && lo_zero);
  assign apply    = busy && (!en || boundary);
  assign nxt_hi   = apply ? shd_hi : act_hi;
  assign nxt_lo   = apply ? shd_lo : act_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi  <= '0;
      act_lo  <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
      phase_q <= PH_LOW;
      ran_q   <= 1'b0;
    end else begin
      act_hi <= nxt_hi;
      act_lo <= nxt_lo;
      if (en) ran_q <= 1'b1;
      if (!en) begin
        pre_q   <= '0;
        cnt_q   <= '0;
        phase_q <= (nxt_hi != '0) ? PH_HIGH : PH_LOW;
      end else begin
        pre_q <= pre_q + 1'b1;
        if (boundary) begin
          cnt_q   <= '0;
          phase_q <= (nxt_hi != '0) ? PH_HIGH : PH_LOW;
        end else if (end_hi) begin
          cnt_q   <= '0;
          phase_q <= PH_LOW;
        end else if (tick) begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign out = en ? (phase_q == PH_HIGH) : (ran_q ? fin_lvl : init_lvl);

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 16,
  parameter int CW  = 16,
  parameter int PW  = 4,
  parameter int AW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic [NCH-1:0] pwm_oe
);
  logic [NCH-1:0]         en_w, busy_w, apply_w, bound_w, hi_zero_w, lo_zero_w;
  logic [NCH-1:0]         init_w, fin_w;
  logic [NCH-1:0][PW-1:0] psc_w;
  logic [NCH-1:0][CW-1:0] shd_hi_w, shd_lo_w;

  pwm_regs #(.NCH(NCH), .CW(CW), .PW(PW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .apply(apply_w),
    .en(en_w), .busy(busy_w), .oe(pwm_oe), .init_lvl(init_w), .fin_lvl(fin_w),
    .psc(psc_w), .shd_hi(shd_hi_w), .shd_lo(shd_lo_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_chan #(.CW(CW), .PW(PW)) u_chan (
      .clk(clk), .rst_n(rst_n), .en(en_w[c]), .busy(busy_w[c]), .psc(psc_w[c]),
      .shd_hi(shd_hi_w[c]), .shd_lo(shd_lo_w[c]), .init_lvl(init_w[c]),
      .fin_lvl(fin_w[c]), .out(pwm_out[c]), .apply(apply_w[c]),
      .boundary(bound_w[c]), .hi_zero(hi_zero_w[c]), .lo_zero(lo_zero_w[c])
    );
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 16,
  parameter int AW  = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [NCH-1:0] bus_wdata,
  input logic [NCH-1:0] en,
  input logic [NCH-1:0] busy,
  input logic [NCH-1:0] apply,
  input logic [NCH-1:0] hi_zero,
  input logic [NCH-1:0] lo_zero,
  input logic [NCH-1:0] pwm_out
);
  logic wr_set, wr_clr, wr_upd;
  assign wr_set = bus_wr && bus_addr == AW'(A_ENSET);
  assign wr_clr = bus_wr && bus_addr == AW'(A_ENCLR);
  assign wr_upd = bus_wr && bus_addr == AW'(A_UPD);

  a_r2_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((en & $past(bus_wdata)) == $past(bus_wdata)));

  a_r2_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((en & $past(bus_wdata)) == '0));

  a_r6_busy_raised: assert property (@(posedge clk) disable iff (!rst_n)
    wr_upd |=> ((busy & $past(bus_wdata)) == $past(bus_wdata)));

  a_r6_busy_drops_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
    ((~busy & $past(busy) & ~$past(apply)) == '0));

  a_r7_idle_update_quick: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(busy & ~en)) && !wr_upd) |=> ((busy & $past(busy & ~en)) == '0));

  a_r5_zero_high_is_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & hi_zero & pwm_out) == '0));

  a_r5_zero_low_is_high: assert property (@(posedge clk) disable iff (!rst_n)
    ((en & lo_zero & ~hi_zero & ~pwm_out) == '0));

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata[NCH-1:0]), .en(en_w), .busy(busy_w), .apply(apply_w),
  .hi_zero(hi_zero_w), .lo_zero(lo_zero_w), .pwm_out(pwm_out)
);

// File: tb/pwm_bank_tb.sv
`timescale 1ns/1ps
module pwm_bank_tb;
  import pwm_bank_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pwm_out, pwm_oe;
  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  pwm_bank u_dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  // {channel, prescale, high ticks, low ticks}
  localparam logic [31:0] VEC [0:4] = '{32'h00_00_03_05, 32'h09_01_02_03,
    32'h00_02_01_01, 32'h0F_00_01_07, 32'h05_03_02_02};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a negedge; the write commits at the following posedge
  task automatic wr(input int unsigned a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 6'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    bus_addr = 6'(a);
    #0.5 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    int ch, ps, hi, lo, errs;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1: reset state
    check("R1 pwm_out", 32'(pwm_out), 0);
    check("R1 pwm_oe", 32'(pwm_oe), 0);
    rd(A_ENSTAT, d); check("R1 enable word", d, 0);
    rd(A_BUSY, d);   check("R1 busy word", d, 0);
    rd(A_WAVE + 3, d); check("R1 wave word", d, 0);
    @(negedge clk);

    // R3, R4: table of waveforms
    for (int v = 0; v < 5; v++) begin
      ch = int'(VEC[v][31:24]); ps = int'(VEC[v][23:16]);
      hi = int'(VEC[v][15:8]);  lo = int'(VEC[v][7:0]);
      wr(A_WAVE + ch, {16'(hi), 16'(lo)});
      wr(ch < 8 ? A_PSC0 : A_PSC1, 32'(ps) << (4 * (ch % 8)));
      wr(A_UPD, 32'd1 << ch);
      wr(A_ENSET, 32'd1 << ch);
      errs = 0;
      for (int i = 0; i < (hi << ps); i++) begin
        if (pwm_out[ch] !== 1'b1) errs++;
        @(negedge clk);
      end
      for (int i = 0; i < (lo << ps); i++) begin
        if (pwm_out[ch] !== 1'b0) errs++;
        @(negedge clk);
      end
      if (pwm_out[ch] !== 1'b1) errs++;
      check("R3/R4 table waveform mismatches", 32'(errs), 0);
      wr(A_ENCLR, 32'd1 << ch);
    end

    // R8: initial and finishing levels
    wr(A_LVL, 32'h0002_0004);
    check("R8 unrun ch2 initial level", 32'(pwm_out[2]), 1);
    check("R8 unrun ch1 initial level", 32'(pwm_out[1]), 0);
    wr(A_ENSET, 32'h2);
    wr(A_ENCLR, 32'h2);
    check("R8 stopped ch1 finishing level", 32'(pwm_out[1]), 1);

    // R9: output enable
    wr(A_OE, 32'h0000_00A5);
    check("R9 pwm_oe", 32'(pwm_oe), 32'h00A5);

    // R5: zero-count waveforms
    wr(A_WAVE + 3, {16'd0, 16'd4});
    wr(A_WAVE + 4, {16'd5, 16'd0});
    wr(A_UPD, 32'h18);
    wr(A_ENSET, 32'h18);
    errs = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out[3] !== 1'b0 || pwm_out[4] !== 1'b1) errs++;
      @(negedge clk);
    end
    check("R5 zero count constant levels", 32'(errs), 0);
    wr(A_ENCLR, 32'h18);

    // R7: update of a stopped channel
    wr(A_WAVE + 6, {16'd2, 16'd2});
    wr(A_UPD, 32'h40);
    rd(A_BUSY, d); check("R7 busy right after request", d, 32'h40);
    @(negedge clk);
    rd(A_BUSY, d); check("R7 busy gone next cycle", d, 0);
    @(negedge clk);

    // R6: update of a running channel lands at the period boundary
    wr(A_PSC0, 0);
    wr(A_WAVE + 0, {16'd4, 16'd4});
    wr(A_UPD, 32'h1);
    wr(A_ENSET, 32'h1);                  // edge E0
    wr(A_WAVE + 0, {16'd2, 16'd6});      // edge E1
    wr(A_UPD, 32'h1);                    // edge E2
    rd(A_BUSY, d); check("R6 busy pending", d, 32'h1);
    check("R6 old high kept at E2", 32'(pwm_out[0]), 1);
    @(negedge clk);
    check("R6 old high kept at E3", 32'(pwm_out[0]), 1);
    idle(4);
    rd(A_BUSY, d); check("R6 busy before boundary", d, 32'h1);
    check("R6 old low at E7", 32'(pwm_out[0]), 0);
    @(negedge clk);
    rd(A_BUSY, d); check("R6 busy cleared at boundary", d, 0);
    check("R6 new high at E8", 32'(pwm_out[0]), 1);
    @(negedge clk);
    check("R6 new high at E9", 32'(pwm_out[0]), 1);
    @(negedge clk);
    check("R6 new high ends at E10", 32'(pwm_out[0]), 0);

    // R10: zero bits do nothing; R2: set and clear words
    wr(A_ENSET, 0);
    wr(A_ENCLR, 0);
    wr(A_UPD, 0);
    rd(A_ENSTAT, d); check("R10 zero writes keep enables", d, 32'h1);
    rd(A_BUSY, d);   check("R10 zero update write no busy", d, 0);
    @(negedge clk);
    wr(A_ENSET, 32'h0300);
    rd(A_ENSTAT, d); check("R2 set bits", d, 32'h0301);
    @(negedge clk);
    wr(A_ENCLR, 32'h0101);
    rd(A_ENSTAT, d); check("R2 clear bits", d, 32'h0200);
    @(negedge clk);

    summary();
  end

endmodule